// File: doc/BRIEF.md
# Four-Direction Maximum Gradient Unit

This streaming block takes an 8-bit grayscale image one pixel per accepted beat, in raster order, and gives each pixel a gradient strength and a coarse orientation. A 3x3 neighbourhood is assembled around every pixel from two rows of history held in a shift chain. Four two-tap differences are taken across the centre: left to right, above to below, and along both diagonals. The largest absolute difference is reported as the magnitude, and a 2-bit code names the axis that produced it.

Frames begin at a pixel flagged with the frame-start marker. After the last pixel of a frame, the block drains its pipeline by itself, so every pixel of the frame receives exactly one result, in raster order. Neighbours that fall outside the image are replaced by the nearest pixel on the border. Image width and height are parameters.

Top module: `edge_grad4`

## Requirements
- R1: A pixel is taken on each rising clock edge where `in_valid` is high. A frame of IMG_W x IMG_H pixels begins with the beat on which `in_sof` is also high. Beats that arrive before any frame start are discarded and produce no output.
- R2: A neighbour position above the top row, below the bottom row, left of column 0 or right of column IMG_W-1 takes the value of the nearest pixel inside the image. The clamp is applied separately to the row and to the column.
- R3: Four absolute differences are formed: horizontal = |right - left|, vertical = |below - above|, falling diagonal = |below-right - above-left|, rising diagonal = |below-left - above-right|. `out_mag` is the largest of the four. It is PIX_W+1 bits wide and its top bit is always 0.
- R4: `out_dir` encodes the winning difference as 0 = horizontal, 1 = vertical, 2 = falling diagonal, 3 = rising diagonal. On a tie, the lowest code wins, so a flat neighbourhood gives magnitude 0 with code 0.
- R5: The result for the pixel at raster index k appears one clock after the beat that carries pixel k+IMG_W+1. At full rate this is IMG_W+2 cycles after pixel k. `out_valid` is never high two cycles after a running-frame cycle with no input beat.
- R6: After the final pixel of a frame, the block makes IMG_W+1 drain beats on consecutive cycles, whatever the input does. `in_valid`, `in_pix` and `in_sof` are ignored during the drain. Each frame yields exactly IMG_W*IMG_H results.
- R7: A beat with `in_sof` high during a running frame abandons that frame. The pixel on that beat becomes raster index 0 of a new frame.
- R8: `in_sol` has no effect on any output.
- R9: While reset is asserted, and directly after it, `out_valid` is low and `out_mag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Grayscale pixel |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_sol | input | 1 | Line-start marker, not used |
| out_valid | output | 1 | Result strobe |
| out_mag | output | PIX_W+1 | Largest directional absolute difference |
| out_dir | output | 2 | Code of the winning direction |

## Verification
Suppose the shift chain or the centre row/column counters drift by one position. Every later result in the frame then uses the wrong neighbours, and a per-pixel comparison against an image-wide model fails at the first non-flat pixel, often within one row. A fault in the beat sequencing shows up as a result in the wrong cycle. The arrival cycle of every result is compared with the cycle of the beat that should complete its window. A drain that stops early, or one that accepts input, changes the per-frame result count or the bottom-row values. Small-range and flat images give frequent ties, which test the tie order directly.

// File: rtl/grad4_pkg.sv
package grad4_pkg;

    typedef enum logic [1:0] {
        DIR_HORZ = 2'd0,
        DIR_VERT = 2'd1,
        DIR_FALL = 2'd2,
        DIR_RISE = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_RUN   = 2'd1,
        M_DRAIN = 2'd2
    } mode_e;

endpackage

// File: rtl/grad4_seq.sv
// Beat sequencing: frame start, drain after the last pixel, centre coordinates.
module grad4_seq
    import grad4_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48,
    parameter int RW    = 6,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    output logic          shift_en,
    output logic          drain,
    output logic          win_ok,
    output logic [RW-1:0] ctr_row,
    output logic [CW-1:0] ctr_col,
    output mode_e         mode
);
    localparam int NPIX  = IMG_W * IMG_H;
    localparam int LASTB = NPIX + IMG_W;
    localparam int NBW   = $clog2(LASTB + 1);
    localparam logic [NBW-1:0] PRIME = NBW'(IMG_W + 1);
    localparam logic [NBW-1:0] LPIX  = NBW'(NPIX - 1);
    localparam logic [NBW-1:0] LBEAT = NBW'(LASTB);

    typedef struct packed {
        mode_e          mode;
        logic [NBW-1:0] nb;
        logic [RW-1:0]  row;
        logic [CW-1:0]  col;
        logic           ok;
    } seq_t;

    seq_t s_d, s_q;
    logic restart, beat;
    logic [NBW-1:0] idx;

    always_comb begin
        s_d     = s_q;
        s_d.ok  = 1'b0;
        restart = in_valid && in_sof && (s_q.mode != M_DRAIN);
        beat    = restart || (s_q.mode == M_DRAIN) || (s_q.mode == M_RUN && in_valid);
        idx     = restart ? '0 : s_q.nb;
        if (beat) begin
            s_d.nb = idx + NBW'(1);
            s_d.ok = (idx >= PRIME);
            if (idx == PRIME) begin
                s_d.row = '0;
                s_d.col = '0;
            end else if (idx > PRIME) begin
                if (s_q.col == CW'(IMG_W - 1)) begin
                    s_d.col = '0;
                    s_d.row = s_q.row + RW'(1);
                end else begin
                    s_d.col = s_q.col + CW'(1);
                end
            end
            if (s_q.mode == M_DRAIN) begin
                if (idx == LBEAT) s_d.mode = M_IDLE;
            end else if (idx == LPIX) begin
                s_d.mode = M_DRAIN;
            end else begin
                s_d.mode = M_RUN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: M_IDLE, nb: '0, row: '0, col: '0, ok: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign shift_en = beat;
    assign drain    = (s_q.mode == M_DRAIN);
    assign win_ok   = s_q.ok;
    assign ctr_row  = s_q.row;
    assign ctr_col  = s_q.col;
    assign mode     = s_q.mode;

endmodule

// File: rtl/grad4_window.sv
// Two rows of history plus three columns as one shift chain; exposes the 3x3 taps.
module grad4_window #(
    parameter int IMG_W = 64,
    parameter int PIX_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [PIX_W-1:0]            pix_in,
    output logic [2:0][2:0][PIX_W-1:0]  win
);
    localparam int NTAP = 2 * IMG_W + 3;

    logic [NTAP-1:0][PIX_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) chain_d = {chain_q[NTAP-2:0], pix_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // row 0 = above, 2 = below; column 0 = left, 2 = right
    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            assign win[r][c] = chain_q[(2 - r) * IMG_W + (2 - c)];
        end
    end

endmodule

// File: rtl/grad4_select.sv
// Border clamp, four directional differences and tie-ordered maximum.
module grad4_select
    import grad4_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48,
    parameter int PIX_W = 8,
    parameter int RW    = 6,
    parameter int CW    = 7
) (
    input  logic [2:0][2:0][PIX_W-1:0] win,
    input  logic [RW-1:0]              ctr_row,
    input  logic [CW-1:0]              ctr_col,
    output logic [PIX_W:0]             mag,
    output dir_e                       dir
);
    logic [2:0][2:0][PIX_W-1:0] nbh;
    logic [3:0][PIX_W:0]        diff;
    logic [3:0][PIX_W-1:0]      ta, tb;

    always_comb begin
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                int sr, sc;
                sr = r;
                sc = c;
                if (r == 0 && ctr_row == '0)              sr = 1;
                if (r == 2 && ctr_row == RW'(IMG_H - 1))  sr = 1;
                if (c == 0 && ctr_col == '0)              sc = 1;
                if (c == 2 && ctr_col == CW'(IMG_W - 1))  sc = 1;
                nbh[r][c] = win[sr][sc];
            end
        end
        ta[0] = nbh[1][2]; tb[0] = nbh[1][0];
        ta[1] = nbh[2][1]; tb[1] = nbh[0][1];
        ta[2] = nbh[2][2]; tb[2] = nbh[0][0];
        ta[3] = nbh[2][0]; tb[3] = nbh[0][2];
        for (int k = 0; k < 4; k++) begin
            diff[k] = (ta[k] > tb[k]) ? {1'b0, ta[k] - tb[k]} : {1'b0, tb[k] - ta[k]};
        end
        mag = diff[0];
        dir = DIR_HORZ;
        for (int k = 1; k < 4; k++) begin
            if (diff[k] > mag) begin
                mag = diff[k];
                dir = dir_e'(k);
            end
        end
    end

endmodule

// File: rtl/edge_grad4.sv
module edge_grad4
    import grad4_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sof,
    input  logic             in_sol,
    output logic             out_valid,
    output logic [PIX_W:0]   out_mag,
    output logic [1:0]       out_dir
);
    localparam int RW = $clog2(IMG_H + 1);
    localparam int CW = $clog2(IMG_W + 1);

    typedef struct packed {
        logic           valid;
        logic [PIX_W:0] mag;
        dir_e           dir;
    } res_t;

    logic                        shift_en, drain, win_ok;
    logic [RW-1:0]               ctr_row;
    logic [CW-1:0]               ctr_col;
    mode_e                       seq_mode;
    logic [2:0][2:0][PIX_W-1:0]  win;
    logic [PIX_W-1:0]            feed;
    logic [PIX_W:0]              sel_mag;
    dir_e                        sel_dir;
    res_t                        res_d, res_q;
    logic                        sol_unused;

    assign sol_unused = in_sol;
    assign feed       = drain ? '0 : in_pix;

    grad4_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H), .RW(RW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .shift_en(shift_en), .drain(drain), .win_ok(win_ok),
        .ctr_row(ctr_row), .ctr_col(ctr_col), .mode(seq_mode)
    );

    grad4_window #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_win (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .pix_in(feed), .win(win)
    );

    grad4_select #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .RW(RW), .CW(CW)) u_sel (
        .win(win), .ctr_row(ctr_row), .ctr_col(ctr_col), .mag(sel_mag), .dir(sel_dir)
    );

    always_comb begin
        res_d = res_q;
        res_d.valid = win_ok;
        if (win_ok) begin
            res_d.mag = sel_mag;
            res_d.dir = sel_dir;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '{valid: 1'b0, mag: '0, dir: DIR_HORZ};
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_mag   = res_q.mag;
    assign out_dir   = res_q.dir;

endmodule

// File: rtl/edge_grad4_chk.sv
module edge_grad4_chk
    import grad4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           out_valid,
    input logic [PIX_W:0] out_mag,
    input logic [1:0]     out_dir,
    input mode_e          mode
);
    AST_MAG_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mag[PIX_W] == 1'b0)); // R3

    AST_FLAT_LOWEST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mag == '0) |-> (out_dir == 2'd0)); // R4

    AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN && !in_valid) |-> ##2 !out_valid); // R5

    AST_DRAIN_STREAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_DRAIN) |-> ##2 out_valid); // R6

endmodule

bind edge_grad4 edge_grad4_chk #(.PIX_W(PIX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_mag(out_mag), .out_dir(out_dir), .mode(seq_mode)
);

// File: tb/test_edge_grad4.sv
module test_edge_grad4;
    localparam int W  = 12;
    localparam int H  = 6;
    localparam int NP = W * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic in_sof = 1'b0;
    logic in_sol = 1'b0;
    logic out_valid;
    logic [8:0] out_mag;
    logic [1:0] out_dir;

    edge_grad4 #(.IMG_W(W), .IMG_H(H), .PIX_W(8)) i_edge_grad4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_sof(in_sof), .in_sol(in_sol), .out_valid(out_valid),
        .out_mag(out_mag), .out_dir(out_dir)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    int n_run = 0, n_fail = 0;
    int img[NP];
    int pcyc[NP];
    int pcount = 0, oidx = 0, lastcyc = 0;
    bit active = 0, done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int px(input int r, input int c);
        int rr = (r < 0) ? 0 : (r >= H ? H - 1 : r);
        int cc = (c < 0) ? 0 : (c >= W ? W - 1 : c);
        return img[rr * W + cc];
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // reference: result for raster index k as {dir, mag}
    function automatic void ref_res(input int k, output int m, output int d);
        int r = k / W, c = k % W;
        int e[4];
        e[0] = iabs(px(r, c + 1) - px(r, c - 1));
        e[1] = iabs(px(r + 1, c) - px(r - 1, c));
        e[2] = iabs(px(r + 1, c + 1) - px(r - 1, c - 1));
        e[3] = iabs(px(r + 1, c - 1) - px(r - 1, c + 1));
        m = e[0]; d = 0;
        for (int i = 1; i < 4; i++) if (e[i] > m) begin m = e[i]; d = i; end
    endfunction

    // drive one cycle of input just after a rising edge
    task automatic beat(input bit v, input int p, input bit s, input bit l);
        @(posedge clk); #1;
        in_valid = v; in_pix = p[7:0]; in_sof = s; in_sol = l;
        if (v) begin
            if (s) begin active = 1; pcount = 0; oidx = 0; end
            if (active && pcount < NP) begin
                img[pcount] = p; pcyc[pcount] = cyc + 1; pcount++;
                if (pcount == NP) lastcyc = cyc + 1;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) beat(0, 0, 0, 0);
    endtask

    function automatic int gen(input int kind);
        case (kind)
            0: return $urandom_range(255, 0);
            1: return $urandom_range(2, 0);
            2: return 77;
            default: return ($urandom_range(1, 0) != 0) ? 255 : 0;
        endcase
    endfunction

    task automatic send(input int kind, input int stall, input int npix);
        for (int i = 0; i < npix; i++) begin
            while ($urandom_range(99, 0) < stall) beat(0, $urandom_range(255, 0), 0, $urandom_range(1, 0));
            beat(1, gen(kind), i == 0, (i % W == 0) ^ ($urandom_range(3, 0) == 0));
        end
    endtask

    task automatic finish_frame(input string tag);
        idle(2 * W + 10);
        chk(oidx == NP, tag, oidx, NP);
    endtask

    // result checker, on the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (!active || oidx >= NP) begin
                chk(0, "R1 R7 unexpected result", 1, 0);
            end else begin
                int m, d, b, ec;
                ref_res(oidx, m, d);
                b  = oidx + W + 1;
                ec = (b < NP) ? pcyc[b] : ((pcount == NP) ? lastcyc + (b - NP) + 1 : -100);
                chk(cyc == ec + 1, "R5 result cycle", cyc, ec + 1);
                chk(out_mag == 9'(m), "R2 R3 magnitude", out_mag, m);
                chk(out_dir == 2'(d), "R4 direction", out_dir, d);
                oidx++;
            end
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk(out_valid == 1'b0, "R9 valid in reset", out_valid, 0);
        chk(out_mag == 9'd0, "R9 mag in reset", out_mag, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
        // R1: beats before any frame start give nothing (checker flags any result)
        for (int i = 0; i < 25; i++) beat(1, $urandom_range(255, 0), 0, 0);
        idle(5);
        chk(oidx == 0, "R1 no frame no result", oidx, 0);
        // full-rate random frame, in_sol scrambled (R8)
        send(0, 0, NP);
        // R6: input during drain must be ignored
        for (int i = 0; i < W + 4; i++) beat(1, $urandom_range(255, 0), 0, 1);
        finish_frame("R6 R8 count full rate");
        send(0, 35, NP);
        finish_frame("R5 R6 count with stalls");
        send(1, 10, NP);
        finish_frame("R4 count tie-heavy");
        send(2, 0, NP);
        finish_frame("R4 count flat");
        send(3, 20, NP);
        finish_frame("R3 count extremes");
        // R7: abandon a frame part way, then restart
        send(0, 0, NP / 2 + 3);
        idle(3);
        send(0, 15, NP);
        finish_frame("R7 count after restart");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule